// File: doc/BRIEF.md
# Local Trigger and Reset Pulse Generator

This block lets an operator create trigger accepts from three board switches and turns a received hard-reset command into a reset pulse of fixed width for the modules downstream.

The switch levels are first passed through two-flop synchronizers. After that, one small state machine reads the three levels together and picks one of three behaviours:

- **Single shot.** Raising switch 0 gives one trigger.
- **Periodic.** When switches 2 and 1 are high and switch 0 is low, triggers repeat with a fixed spacing.
- **Clock-manager reset.** When all three switches are high, the block drives a reset request to the clock manager and produces no triggers.

A second state machine watches an 8-bit command byte and its strobe:

- The hard-reset code opens a timed pulse. A later hard-reset strobe restarts that pulse.
- The synchronous-reset code is passed on as a one-cycle strobe.

The hard-reset pulse is meant only for the downstream modules. It never resets this block.

The mode machine has three states:

- `MODE_IDLE` is the single-shot mode.
- `MODE_PERIODIC` runs the periodic timer.
- `MODE_CLKRST` holds the clock-manager request.

Its transitions are:

- IDLE→PERIODIC and CLKRST→PERIODIC, when only switches 2 and 1 are high.
- IDLE→CLKRST and PERIODIC→CLKRST, when all three switches are high.
- PERIODIC→IDLE and CLKRST→IDLE, when switches 2 and 1 are not both high.

The pulser has two states, `PLS_IDLE` and `PLS_ACTIVE`:

- PLS_IDLE→PLS_ACTIVE happens on a hard-reset strobe.
- PLS_ACTIVE→PLS_ACTIVE happens on a new hard-reset strobe, which restarts the count.
- PLS_ACTIVE→PLS_IDLE happens after the last cycle of the pulse.

Top module: `trig_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, all four outputs are low.
- R2: A rise of `sw_i[0]` while `sw_i[2:1]` are not both high gives exactly one `trig_o` cycle. Holding the switch high, or lowering it, gives no further trigger.
- R3: With `sw_i` = 3'b110, `trig_o` pulses every PERIOD_CYC cycles. The first pulse comes PERIOD_CYC cycles after the mode takes effect.
- R4: Leaving periodic mode and entering it again restarts the timer from zero. The first trigger after re-entry is a full PERIOD_CYC away.
- R5: With `sw_i` = 3'b111, `clkmgr_rst_o` is high and `trig_o` stays low. The request drops when any switch goes low.
- R6: A strobe with `cmd_i` = 8'h04 raises `hard_rst_o` on the next cycle, for exactly PULSE_CYC cycles.
- R7: Another 8'h04 strobe during the pulse restarts the count. `hard_rst_o` falls PULSE_CYC cycles after the last strobe.
- R8: A strobe with `cmd_i` = 8'h03 gives a one-cycle `sync_rst_o` on the next cycle, independent of the hard-reset pulse.
- R9: Any other command code, or any code without `cmd_stb_i`, has no effect on the outputs.
- R10: A hard-reset command does not disturb trigger generation, so the periodic trigger timing is unchanged.
- R11: Dropping `sw_i[0]` from 3'b111 to 3'b110 releases `clkmgr_rst_o` and enters periodic mode with the timer at zero. No trigger is produced by the transition itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_i | input | 3 | Switch levels (bit 0: single/clock-reset select, bits 2:1: periodic select) |
| cmd_i | input | 8 | Received command code |
| cmd_stb_i | input | 1 | Qualifies `cmd_i` for one cycle |
| trig_o | output | 1 | One-cycle trigger accept |
| hard_rst_o | output | 1 | Timed hard-reset pulse for downstream modules |
| sync_rst_o | output | 1 | One-cycle synchronous-reset strobe |
| clkmgr_rst_o | output | 1 | Reset request to the clock manager |

## Verification
Switch changes are seen on the third rising edge that samples the new level: two synchronizer stages, then the registered mode outputs. Command effects appear on the edge that samples the strobe.

A periodic trigger is due PERIOD_CYC edges after the mode register changes. The hard pulse falls PULSE_CYC edges after its last strobe.

The bench drives inputs and samples outputs on the falling edge. It counts rows from the edge that first samples a stimulus and compares every row against these offsets, so a result one cycle early or late fails.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_CLKRST   = 2'd2
    } trig_mode_e;

    typedef enum logic {
        PLS_IDLE   = 1'b0,
        PLS_ACTIVE = 1'b1
    } pulse_st_e;

endpackage

// File: rtl/trg_sw_sync.sv
module trg_sw_sync #(
    parameter int N_SW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_SW-1:0] sw_i,
    output logic [N_SW-1:0] lvl_o
);

    for (genvar g = 0; g < N_SW; g++) begin : g_sync
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= sw_i[g];
                stab_q <= meta_q;
            end
        end

        assign lvl_o[g] = stab_q;
    end

endmodule

// File: rtl/trg_mode_fsm.sv
module trg_mode_fsm
    import trg_pkg::*;
#(
    parameter int PERIOD_CYC = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] lvl_i,
    output logic       trig_o,
    output logic       clkmgr_rst_o
);

    localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    trig_mode_e state_q;
    trig_mode_e state_n;
    logic [CW-1:0] tmr_q;
    logic lvl0_prev_q;
    logic want_clk;
    logic want_per;
    logic rise0;
    logic trig_n;

    assign want_clk = &lvl_i;
    assign want_per = lvl_i[2] & lvl_i[1] & ~lvl_i[0];
    assign rise0 = lvl_i[0] & ~lvl0_prev_q;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            MODE_IDLE: begin
                if (want_clk)      state_n = MODE_CLKRST;
                else if (want_per) state_n = MODE_PERIODIC;
            end
            MODE_PERIODIC: begin
                if (want_clk)       state_n = MODE_CLKRST;
                else if (!want_per) state_n = MODE_IDLE;
            end
            MODE_CLKRST: begin
                if (!want_clk) state_n = want_per ? MODE_PERIODIC : MODE_IDLE;
            end
            default: state_n = MODE_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Periodic timer, cleared on every entry into periodic mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (state_n == MODE_PERIODIC && state_q != MODE_PERIODIC) begin
            tmr_q <= '0;
        end else if (state_q == MODE_PERIODIC) begin
            tmr_q <= (tmr_q == LAST) ? '0 : tmr_q + 1'b1;
        end
    end

    always_comb begin
        trig_n = 1'b0;
        if (state_q == MODE_IDLE && state_n == MODE_IDLE && rise0) begin
            trig_n = 1'b1;
        end
        if (state_q == MODE_PERIODIC && state_n == MODE_PERIODIC && tmr_q == LAST) begin
            trig_n = 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_o       <= 1'b0;
            clkmgr_rst_o <= 1'b0;
            lvl0_prev_q  <= 1'b0;
        end else begin
            trig_o       <= trig_n;
            clkmgr_rst_o <= (state_n == MODE_CLKRST);
            lvl0_prev_q  <= lvl_i[0];
        end
    end

endmodule

// File: rtl/trg_rst_pulser.sv
module trg_rst_pulser
    import trg_pkg::*;
#(
    parameter int          CMD_W     = 8,
    parameter logic [7:0]  HARD_CODE = 8'h04,
    parameter logic [7:0]  SYNC_CODE = 8'h03,
    parameter int          PULSE_CYC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             cmd_stb_i,
    output logic             hard_rst_o,
    output logic             sync_rst_o
);

    localparam int CW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    pulse_st_e state_q;
    pulse_st_e state_n;
    logic [CW-1:0] cnt_q;
    logic hit_hard;
    logic hit_sync;

    assign hit_hard = cmd_stb_i && (cmd_i == CMD_W'(HARD_CODE));
    assign hit_sync = cmd_stb_i && (cmd_i == CMD_W'(SYNC_CODE));

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PLS_IDLE: begin
                if (hit_hard) state_n = PLS_ACTIVE;
            end
            PLS_ACTIVE: begin
                if (hit_hard)            state_n = PLS_ACTIVE;
                else if (cnt_q == LAST)  state_n = PLS_IDLE;
            end
            default: state_n = PLS_IDLE;
        endcase
    end

    // State register and width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PLS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (hit_hard) begin
                cnt_q <= '0;
            end else if (state_q == PLS_ACTIVE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hard_rst_o <= 1'b0;
            sync_rst_o <= 1'b0;
        end else begin
            hard_rst_o <= (state_n == PLS_ACTIVE);
            sync_rst_o <= hit_sync;
        end
    end

endmodule

// File: rtl/trig_reset_ctrl.sv
module trig_reset_ctrl #(
    parameter int         CMD_W      = 8,
    parameter logic [7:0] HARD_CODE  = 8'h04,
    parameter logic [7:0] SYNC_CODE  = 8'h03,
    parameter int         PULSE_CYC  = 32,
    parameter int         PERIOD_CYC = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sw_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             cmd_stb_i,
    output logic             trig_o,
    output logic             hard_rst_o,
    output logic             sync_rst_o,
    output logic             clkmgr_rst_o
);

    localparam int N_SW = 3;

    logic [N_SW-1:0] sw_lvl;

    trg_sw_sync #(
        .N_SW (N_SW)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_i  (sw_i),
        .lvl_o (sw_lvl)
    );

    trg_mode_fsm #(
        .PERIOD_CYC (PERIOD_CYC)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (sw_lvl),
        .trig_o       (trig_o),
        .clkmgr_rst_o (clkmgr_rst_o)
    );

    trg_rst_pulser #(
        .CMD_W     (CMD_W),
        .HARD_CODE (HARD_CODE),
        .SYNC_CODE (SYNC_CODE),
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .cmd_stb_i  (cmd_stb_i),
        .hard_rst_o (hard_rst_o),
        .sync_rst_o (sync_rst_o)
    );

endmodule

// File: rtl/trig_reset_chk.sv
module trig_reset_chk #(
    parameter int         CMD_W     = 8,
    parameter logic [7:0] HARD_CODE = 8'h04,
    parameter logic [7:0] SYNC_CODE = 8'h03,
    parameter int         PULSE_CYC = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CMD_W-1:0] cmd_i,
    input logic             cmd_stb_i,
    input logic             trig_o,
    input logic             hard_rst_o,
    input logic             sync_rst_o,
    input logic             clkmgr_rst_o
);

    localparam int HW = $clog2(PULSE_CYC + 1);
    localparam logic [HW-1:0] PW = HW'(PULSE_CYC);

    logic is_hard;
    logic is_sync;
    logic [HW-1:0] hi_cnt;

    assign is_hard = cmd_stb_i && (cmd_i == CMD_W'(HARD_CODE));
    assign is_sync = cmd_stb_i && (cmd_i == CMD_W'(SYNC_CODE));

    // Cycles the hard pulse has been high since its last strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (is_hard)    hi_cnt <= '0;
        else if (hard_rst_o) hi_cnt <= hi_cnt + 1'b1;
    end

    // R2: a trigger lasts one cycle
    a_r2_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R5: no trigger while the clock-manager request is up
    a_r5_clk_blocks_trig: assert property (@(posedge clk) disable iff (!rst_n)
        clkmgr_rst_o |-> !trig_o);

    // R6: pulse starts on the cycle after the strobe
    a_r6_hard_starts: assert property (@(posedge clk) disable iff (!rst_n)
        is_hard |=> hard_rst_o);

    // R6, R7: pulse width counted from the last strobe
    a_r7_hard_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_rst_o) |-> (hi_cnt == PW));

    // R9: the pulse only starts from a qualified hard code
    a_r9_hard_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_rst_o) |-> $past(is_hard));

    // R8: sync strobe follows the sync code
    a_r8_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        is_sync |=> sync_rst_o);

    // R9: sync strobe has no other cause
    a_r9_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst_o |-> $past(is_sync));

endmodule

bind trig_reset_ctrl trig_reset_chk #(
    .CMD_W     (CMD_W),
    .HARD_CODE (HARD_CODE),
    .SYNC_CODE (SYNC_CODE),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .cmd_stb_i    (cmd_stb_i),
    .trig_o       (trig_o),
    .hard_rst_o   (hard_rst_o),
    .sync_rst_o   (sync_rst_o),
    .clkmgr_rst_o (clkmgr_rst_o)
);

// File: tb/tb_trig_reset_ctrl.sv
module tb_trig_reset_ctrl;

    localparam int PULSE  = 5;
    localparam int PERIOD = 16;
    localparam int NVEC   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sw = 3'b000;
    logic [7:0] cmd = 8'h00;
    logic       stb = 1'b0;
    logic       trig, hard, sync_r, clkr;

    int n_cmp = 0;
    int n_bad = 0;

    // Row: {sw[2:0], cmd[7:0], stb, exp trig, exp hard, exp sync, exp clkmgr}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {3'b000, 8'h00, 1'b0, 4'b0000},
        {3'b001, 8'h00, 1'b0, 4'b0000},
        {3'b001, 8'h00, 1'b0, 4'b0000},
        {3'b001, 8'h00, 1'b0, 4'b1000},
        {3'b001, 8'h00, 1'b0, 4'b0000},
        {3'b000, 8'h03, 1'b1, 4'b0010},
        {3'b000, 8'h05, 1'b1, 4'b0000},
        {3'b000, 8'h04, 1'b0, 4'b0000},
        {3'b000, 8'h04, 1'b1, 4'b0100},
        {3'b000, 8'h00, 1'b0, 4'b0100},
        {3'b000, 8'h03, 1'b1, 4'b0110},
        {3'b000, 8'h00, 1'b0, 4'b0100},
        {3'b000, 8'h00, 1'b0, 4'b0100},
        {3'b000, 8'h00, 1'b0, 4'b0000},
        {3'b111, 8'h00, 1'b0, 4'b0000},
        {3'b111, 8'h00, 1'b0, 4'b0000},
        {3'b111, 8'h00, 1'b0, 4'b0001},
        {3'b000, 8'h00, 1'b0, 4'b0001},
        {3'b000, 8'h00, 1'b0, 4'b0001},
        {3'b000, 8'h00, 1'b0, 4'b0000}
    };

    trig_reset_ctrl #(
        .PULSE_CYC  (PULSE),
        .PERIOD_CYC (PERIOD)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_i         (sw),
        .cmd_i        (cmd),
        .cmd_stb_i    (stb),
        .trig_o       (trig),
        .hard_rst_o   (hard),
        .sync_rst_o   (sync_r),
        .clkmgr_rst_o (clkr)
    );

    always #10ns clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // R3 R4 R10 R11: periodic run, row 0 is the first edge sampling sw=110
    task automatic run_periodic(input string tag, input bit inject, input bit from_clk);
        sw = 3'b110;
        for (int i = 0; i < 60; i++) begin
            if (inject && i == 25) begin
                cmd = 8'h04; stb = 1'b1;
            end else begin
                cmd = 8'h00; stb = 1'b0;
            end
            tick();
            chk(tag, "trig", trig, (i >= 18) && ((i - 18) % PERIOD == 0));
            chk(tag, "clkmgr", clkr, from_clk && (i < 2));
            chk(tag, "hard", hard, inject && (i >= 25) && (i < 25 + PULSE));
        end
        stb = 1'b0;
    endtask

    initial begin
        #4ms;
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        sw = 3'b111; cmd = 8'h04; stb = 1'b1;
        tick(); tick(); tick();
        chk("R1", "trig", trig, 1'b0);
        chk("R1", "hard", hard, 1'b0);
        chk("R1", "sync", sync_r, 1'b0);
        chk("R1", "clkmgr", clkr, 1'b0);
        sw = 3'b000; cmd = 8'h00; stb = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();

        // Vector table: R2 single shot, R8 sync, R9 ignored codes, R6 width, R5 clock reset
        for (int v = 0; v < NVEC; v++) begin
            sw  = VEC[v][15:13];
            cmd = VEC[v][12:5];
            stb = VEC[v][4];
            tick();
            chk("R2/R5/R6/R8/R9 table", "trig", trig, VEC[v][3]);
            chk("R6/R9 table", "hard", hard, VEC[v][2]);
            chk("R8/R9 table", "sync", sync_r, VEC[v][1]);
            chk("R5 table", "clkmgr", clkr, VEC[v][0]);
        end
        stb = 1'b0;

        // R3 periodic spacing, R10 hard command leaves timing intact
        run_periodic("R3/R10", 1'b1, 1'b0);

        // R4 leave and re-enter periodic
        sw = 3'b000;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R4 idle", "trig", trig, 1'b0);
        end
        run_periodic("R4", 1'b0, 1'b0);

        // R5 clock-manager reset holds off triggers
        sw = 3'b111;
        for (int i = 0; i < 40; i++) begin
            tick();
            chk("R5", "trig", trig, 1'b0);
            chk("R5", "clkmgr", clkr, i >= 2);
        end

        // R11 drop switch 0 from 111 into periodic
        run_periodic("R11", 1'b0, 1'b1);

        // R7 restart of the hard pulse
        sw = 3'b000;
        for (int i = 0; i < 4; i++) tick();
        for (int i = 0; i < 12; i++) begin
            if (i == 0 || i == 3) begin
                cmd = 8'h04; stb = 1'b1;
            end else begin
                cmd = 8'h00; stb = 1'b0;
            end
            tick();
            chk("R7", "hard", hard, i < 3 + PULSE);
        end
        stb = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule